// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external SPI master read and write a small bank of 16-bit registers. The master drives the serial clock, an active-low chip select and the master-to-slave data line. The block answers on the slave-to-master data line. All three inputs are asynchronous to the block. Each one passes through a synchroniser into a system clock that runs at least four times faster than the serial clock. Clock and chip-select edges are then found from the synchronised samples.

One transaction is exactly one chip-select window. It carries a 32-bit frame: an address word followed by a data word, each 16 bits long and sent most significant bit first. The master may send the two words back to back. The serial clock idles low and data is captured on the falling edge, so the block changes its output on the rising edge.

For a write, the data word is stored when chip select rises, but only if the frame was exactly 32 bits long. For a read, the master sends a dummy second word. While it does, the block shifts the addressed register out.

Top module: `spi_regport`

## Requirements
- R1: Bit 15 of the address word selects the operation (1 = read, 0 = write). Address bits 3..0 select one of 16 registers, and address bits 14..4 are ignored.
- R2: A write frame stores its data word into the addressed register when chip select rises. A read frame changes no register, whatever its second word holds.
- R3: A frame of any length other than exactly 32 captured bits changes no register.
- R4: During the second word of a read frame, miso_o presents the addressed register's value, most significant bit first. The first data bit is already valid at the first falling edge of the second word, with no idle clocks needed between the words.
- R5: miso_o is 0 throughout the address word of every frame and throughout every write frame.
- R6: miso_oe_o is 1 while the synchronised chip select is low and 0 otherwise. miso_o is 0 whenever miso_oe_o is 0.
- R7: The block captures the data input on falling serial-clock edges and changes miso_o only on rising serial-clock edges (clock idle low).
- R8: A synchronous active-low reset clears all registers, the bit counter and both shift registers, and leaves miso_oe_o and miso_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master, idles low |
| csn_i | input | 1 | Active-low chip select from the master |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for miso_o, high while selected |

## Verification
Every pin edge reaches the logic two system clocks after it occurs, through the synchroniser. It is acted on in the third clock, in which the registers update. So the output for a rising serial-clock edge is settled about three clocks after that edge. The bench holds each serial-clock half period at five system clocks and reads miso_o just before it drives the next falling edge. Writes are committed about three clocks after chip select rises, and the bench waits twelve clocks before it starts the read frame that checks them. All inputs are driven and all outputs read on the falling edge of the system clock.

// File: rtl/spi_regport_pkg.sv
// Package: shared operation encoding for the SPI register port.
// Assumes: address and data words have the same width.
package spi_regport_pkg;

    // Operation selected by the most significant bit of the address word.
    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } spi_op_e;

endpackage

// File: rtl/spi_regport_sync.sv
// Module: multi-flop synchroniser for one asynchronous input.
// Assumes: STAGES >= 2; the input is a level that changes slowly relative to clk.
module spi_regport_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Sample the raw asynchronous pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_next
                // Pass the sample down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign level_o = chain_q[STAGES-1];

endmodule

// File: rtl/spi_regport_edge.sv
// Module: rise/fall detector on an already synchronised level.
// Assumes: the level is synchronous to clk.
module spi_regport_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_q;

    // Remember the level from the previous system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= level_i;
    end

    assign rise_o =  level_i & ~prev_q;
    assign fall_o = ~level_i &  prev_q;

endmodule

// File: rtl/spi_regport_regfile.sv
// Module: register file of REG_CNT words, one write port, one combinational read port.
// Assumes: REG_CNT is a power of two so every index is in range.
module spi_regport_regfile #(
    parameter int WORD_W  = 16,
    parameter int REG_CNT = 16,
    localparam int IDX_W  = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [WORD_W-1:0] rd_data_o
);

    logic [WORD_W-1:0] mem_q [REG_CNT];

    generate
        for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
            // Hold one register; load it when its index is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem_q[g] <= '0;
                else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
                    mem_q[g] <= wr_data_i;
            end
        end
    endgenerate

    assign rd_data_o = mem_q[rd_idx_i];

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (mem_q[$past(wr_idx_i)] == $past(wr_data_i)));

endmodule

// File: rtl/spi_regport_frame.sv
// Module: frame engine; counts bits, assembles the address and data words,
// decodes read/write, drives the outgoing shift register and issues writes.
// Assumes: inputs are synchronised; sclk edges are at least two clk apart.
module spi_regport_frame
    import spi_regport_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_i,
    input  logic              cs_fall_i,
    input  logic              cs_rise_i,
    input  logic              sclk_rise_i,
    input  logic              sclk_fall_i,
    input  logic              mosi_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic [IDX_W-1:0]  rd_idx_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              miso_bit_o,
    output logic              miso_oe_o
);

    localparam int FRAME_BITS = 2 * WORD_W;
    localparam int CNT_MAX    = FRAME_BITS + 1;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0]  bit_cnt_q;
    logic [WORD_W-1:0] rx_q;
    logic [WORD_W-1:0] tx_q;
    logic [IDX_W-1:0]  idx_q;
    spi_op_e           op_q;
    logic              rd_active_q;
    logic              hold_first_q;

    logic              capture;
    logic              launch;
    logic              word_done;
    logic [WORD_W-1:0] rx_next;

    // Qualify serial-clock edges with chip select.
    always_comb begin
        capture   = !csn_i && sclk_fall_i;
        launch    = !csn_i && sclk_rise_i;
        rx_next   = {rx_q[WORD_W-2:0], mosi_i};
        word_done = capture && (bit_cnt_q == CNT_W'(WORD_W - 1));
    end

    // Shift, count and decode the frame; shift read data out on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_fall_i) begin
            bit_cnt_q    <= '0;
            rx_q         <= '0;
            tx_q         <= '0;
            idx_q        <= '0;
            op_q         <= OP_WRITE;
            rd_active_q  <= 1'b0;
            hold_first_q <= 1'b0;
        end else begin
            if (capture) begin
                rx_q <= rx_next;
                if (bit_cnt_q != CNT_W'(CNT_MAX))
                    bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (word_done) begin
                idx_q <= rx_next[IDX_W-1:0];
                op_q  <= spi_op_e'(rx_next[WORD_W-1]);
                if (rx_next[WORD_W-1]) begin
                    tx_q         <= rd_data_i;
                    rd_active_q  <= 1'b1;
                    hold_first_q <= 1'b1;
                end
            end else if (launch && rd_active_q) begin
                if (hold_first_q) hold_first_q <= 1'b0;
                else              tx_q <= {tx_q[WORD_W-2:0], 1'b0};
            end
        end
    end

    // Commit a write only for an exact-length write frame.
    always_comb begin
        rd_idx_o   = rx_next[IDX_W-1:0];
        wr_en_o    = cs_rise_i && (bit_cnt_q == CNT_W'(FRAME_BITS)) && (op_q == OP_WRITE);
        wr_idx_o   = idx_q;
        wr_data_o  = rx_q;
        miso_bit_o = rd_active_q & tx_q[WORD_W-1];
        miso_oe_o  = !csn_i;
    end

    // R3
    odd_length_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise_i && (bit_cnt_q != CNT_W'(FRAME_BITS))) |-> !wr_en_o);

    // R5
    addr_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt_q < CNT_W'(WORD_W)) |-> !miso_bit_o);

    // R4
    read_load_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_active_q) |-> (bit_cnt_q == CNT_W'(WORD_W)));

    // R7
    tx_moves_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active_q && !launch && !cs_fall_i) |=> $stable(tx_q));

    // R7
    rx_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !cs_fall_i) |=> $stable(rx_q));

endmodule

// File: rtl/spi_regport.sv
// Module: top of the SPI register port; synchronises the pins, finds edges,
// runs the frame engine and holds the register file.
// Assumes: clk is at least four times the serial clock; clock mode with idle
// low and capture on the falling edge.
module spi_regport #(
    parameter int WORD_W      = 16,
    parameter int REG_CNT     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic csn_i,
    input  logic mosi_i,
    output logic miso_o,
    output logic miso_oe_o
);

    localparam int IDX_W = $clog2(REG_CNT);

    logic              sclk_s, csn_s, mosi_s;
    logic              sclk_rise, sclk_fall, cs_rise, cs_fall;
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [WORD_W-1:0] rd_data, wr_data;
    logic              wr_en, miso_bit, oe;

    spi_regport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .async_i(sclk_i), .level_o(sclk_s));
    spi_regport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
        .clk(clk), .rst_n(rst_n), .async_i(csn_i), .level_o(csn_s));
    spi_regport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst_n(rst_n), .async_i(mosi_i), .level_o(mosi_s));

    spi_regport_edge #(.RST_VAL(1'b0)) u_edge_sclk (
        .clk(clk), .rst_n(rst_n), .level_i(sclk_s), .rise_o(sclk_rise), .fall_o(sclk_fall));
    spi_regport_edge #(.RST_VAL(1'b1)) u_edge_csn (
        .clk(clk), .rst_n(rst_n), .level_i(csn_s), .rise_o(cs_rise), .fall_o(cs_fall));

    spi_regport_frame #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .csn_i(csn_s), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
        .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall), .mosi_i(mosi_s),
        .rd_data_i(rd_data), .rd_idx_o(rd_idx), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
        .wr_data_o(wr_data), .miso_bit_o(miso_bit), .miso_oe_o(oe));

    spi_regport_regfile #(.WORD_W(WORD_W), .REG_CNT(REG_CNT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .rd_idx_i(rd_idx), .rd_data_o(rd_data));

    // Gate the serial output with its enable.
    always_comb begin
        miso_oe_o = oe;
        miso_o    = oe & miso_bit;
    end

    // R6
    release_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !miso_oe_o);

    // R6
    quiet_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |-> !miso_o);

endmodule

// File: tb/sim_spi_regport.sv
// Bench: directed scenarios against spi_regport, one task for each, each checking itself.
module sim_spi_regport;

    localparam int HALF = 5;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic sclk  = 1'b0;
    logic csn   = 1'b1;
    logic mosi  = 1'b0;
    logic miso, miso_oe;

    int  errs   = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    spi_regport u0 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
        .miso_o(miso), .miso_oe_o(miso_oe));

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one frame of nbits, master changes data on rise, slave output read before fall.
    task automatic frame(input int nbits, input logic [63:0] word,
                         output logic [63:0] cap, output bit oe_ok);
        cap   = '0;
        oe_ok = 1'b1;
        @(negedge clk);
        csn = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1;
            mosi = word[nbits-1-i];
            wait_clk(HALF);
            cap = {cap[62:0], miso};
            if (miso_oe !== 1'b1) oe_ok = 1'b0;
            sclk = 1'b0;
            wait_clk(HALF);
        end
        csn  = 1'b1;
        mosi = 1'b0;
        wait_clk(12);
    endtask

    task automatic spi_write(input logic [15:0] addr, input logic [15:0] data,
                             output logic [31:0] cap32, output bit oe_ok);
        logic [63:0] cap;
        frame(32, {32'h0, addr, data}, cap, oe_ok);
        cap32 = cap[31:0];
    endtask

    task automatic spi_read(input logic [15:0] addr, input logic [15:0] dummy,
                            output logic [15:0] data, output logic [15:0] addr_phase);
        logic [63:0] cap;
        bit          oe_ok;
        frame(32, {32'h0, addr, dummy}, cap, oe_ok);
        data       = cap[15:0];
        addr_phase = cap[31:16];
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        wait_clk(4);
        chk("R8 reset oe", 32'(miso_oe), 32'h0);
        chk("R8 reset miso", 32'(miso), 32'h0);
        rst_n = 1'b1;
        wait_clk(4);
        chk("R6 idle oe", 32'(miso_oe), 32'h0);
    endtask

    task automatic t_write_read(input logic [3:0] idx, input logic [15:0] val);
        logic [31:0] wcap;
        logic [15:0] rd, ap;
        bit          oe_ok;
        spi_write({12'h000, idx}, val, wcap, oe_ok);
        chk("R5 miso zero in write frame", wcap, 32'h0);
        chk("R6 oe high while selected", 32'(oe_ok), 32'h1);
        chk("R6 oe low after frame", 32'(miso_oe), 32'h0);
        spi_read({12'h800, idx}, 16'h0000, rd, ap);
        chk("R4 R7 read data", 32'(rd), 32'(val));
        chk("R5 miso zero in address word", 32'(ap), 32'h0);
    endtask

    task automatic t_upper_addr_ignored();
        logic [15:0] rd, ap;
        spi_read(16'hBFF7, 16'h0000, rd, ap);
        chk("R1 address bits 14..4 ignored", 32'(rd), 32'h8000);
    endtask

    task automatic t_bad_length();
        logic [63:0] cap;
        logic [15:0] rd, ap;
        bit          oe_ok;
        frame(31, {32'h0, 16'h0003, 16'h1234} >> 1, cap, oe_ok);
        spi_read(16'h8003, 16'h0000, rd, ap);
        chk("R3 31-bit frame discarded", 32'(rd), 32'hA5C3);
        frame(33, {31'h0, 16'h0003, 16'h5678, 1'b0}, cap, oe_ok);
        spi_read(16'h8003, 16'h0000, rd, ap);
        chk("R3 33-bit frame discarded", 32'(rd), 32'hA5C3);
    endtask

    task automatic t_read_no_write();
        logic [15:0] rd, ap;
        spi_read(16'h8003, 16'h5555, rd, ap);
        chk("R2 read frame returns value", 32'(rd), 32'hA5C3);
        spi_read(16'h8003, 16'h0000, rd, ap);
        chk("R2 read frame stores nothing", 32'(rd), 32'hA5C3);
    endtask

    task automatic t_reset_clears();
        logic [15:0] rd, ap;
        @(negedge clk);
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(4);
        spi_read(16'h800F, 16'h0000, rd, ap);
        chk("R8 register cleared by reset", 32'(rd), 32'h0);
        spi_read(16'h8003, 16'h0000, rd, ap);
        chk("R8 register cleared by reset", 32'(rd), 32'h0);
    endtask

    initial begin
        t_reset_state();
        t_write_read(4'h3, 16'hA5C3);
        t_write_read(4'hF, 16'hFFFF);
        t_write_read(4'h0, 16'h0001);
        t_write_read(4'h7, 16'h8000);
        t_upper_addr_ignored();
        t_bad_length();
        t_read_no_write();
        t_reset_clears();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule